// File: doc/BRIEF.md
# Rotating Overhead Byte Capture

This block takes a framed, byte-wide SONET/SDH stream, in which each byte carries its row, its overhead column and its STS-1 number, and copies one transport-overhead byte per STS-1 into a buffer. The buffer serves as an in-band message channel from upstream equipment. A processor picks the overhead byte (row 0 to 8, overhead column 0 to 2). The block does not sample every STS-1 in every frame. It spreads the work over a cycle of twelve frames, and each frame covers one contiguous group of STS-1s.

Each frame of the cycle writes one group of G = NUM_STS / CYCLE_FRAMES entries. A flag goes up once the group of the last frame has landed, and a processor read clears it. Changing the byte selection restarts the cycle. Losing frame alignment also restarts it, so every finished cycle holds bytes from a single selection and an unbroken run of frames.

Top module: `oh_rotcap`

## Requirements
- R1: A read strobe `rd_en` with address s returns buffer entry s on `rd_data`, with `rd_valid` high, in the cycle after the strobe. `rd_valid` is low in every other cycle.
- R2: The selection is a row (0 to 8) and an overhead column (0 to 2). A `cfg_we` write with row greater than 8 or column greater than 2 is ignored: the selection and the running cycle stay as they were.
- R3: In frame k of the cycle (k = 0 to CYCLE_FRAMES-1), entry s is written with the selected overhead byte of STS-1 s only when k·G ≤ s ≤ k·G+G−1. All other entries keep their contents.
- R4: The first frame start that is not out of frame, arriving after reset, after an accepted selection write or after an out-of-frame period, begins frame 0. Each later frame start advances the frame number by one, and it wraps from CYCLE_FRAMES-1 back to 0.
- R5: `cycle_done` rises in the cycle after the byte of STS-1 NUM_STS-1 is captured in frame CYCLE_FRAMES-1. It stays high until it is cleared.
- R6: A read strobe clears `cycle_done` at that clock edge. If a completing capture happens on the same edge, the flag is set instead.
- R7: An accepted selection write restarts the cycle, and no byte is captured in the cycle of the write.
- R8: While `in_oof` is high, nothing is captured and the cycle position is lost.
- R9: A byte with `in_valid` low or `in_toh` low is never captured, even when its row, column and STS-1 number match.
- R10: After reset, `cycle_done` and `rd_valid` are low and the selection is row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A stream byte is present |
| in_frame_start | input | 1 | Marks the first byte of a frame |
| in_oof | input | 1 | The framer reports out of frame |
| in_toh | input | 1 | The byte belongs to the transport overhead |
| in_row | input | 4 | Row index of the byte (0 to 8) |
| in_col | input | 2 | Overhead column of the byte (0 to 2) |
| in_sts | input | STS_W | STS-1 number of the byte |
| in_data | input | DATA_W | Byte value |
| cfg_we | input | 1 | Write strobe for the byte selection |
| cfg_row | input | 4 | Selected row |
| cfg_col | input | 2 | Selected overhead column |
| rd_en | input | 1 | Buffer read strobe |
| rd_addr | input | STS_W | Buffer entry (STS-1 number) to read |
| rd_data | output | DATA_W | Read result |
| rd_valid | output | 1 | `rd_data` holds a read result |
| cycle_done | output | 1 | A complete capture cycle is in the buffer |

## Verification
A capture takes effect at the clock edge that samples the matching byte. A read strobe gives its result one edge later. `cycle_done` changes at the edge of the completing capture or of the clearing read. The bench drives every input on the falling edge and samples one falling edge after the edge that matters. It reads the buffer only after a frame has been fully sent, and it reads `cycle_done` only after the last byte of a frame. The bench keeps a model of the buffer: it records the byte value it drove for each STS-1 in the frame whose group covers that STS-1, and it compares the model with a sweep of every buffer address.

// File: rtl/oh_rotcap_pkg.sv
package oh_rotcap_pkg;

   localparam int OH_ROWS = 9;
   localparam int OH_COLS = 3;

   typedef struct packed {
      logic [3:0] row;
      logic [1:0] col;
   } oh_pos_t;

   function automatic logic oh_pos_legal(input oh_pos_t p);
      return (int'(p.row) < OH_ROWS) && (int'(p.col) < OH_COLS);
   endfunction

endpackage

// File: rtl/oh_rotcap_seq.sv
module oh_rotcap_seq #(
   parameter int FRAMES = 12,
   parameter int PH_W   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            frame_mark,
   output logic [PH_W-1:0] phase_eff,
   output logic            sync_eff
);

   logic [PH_W-1:0] phase_q;
   logic            sync_q;

   always_comb begin
      phase_eff = phase_q;
      sync_eff  = sync_q;
      if (frame_mark) begin
         if (!sync_q) begin
            sync_eff  = 1'b1;
            phase_eff = '0;
         end else if (int'(phase_q) == FRAMES - 1) begin
            phase_eff = '0;
         end else begin
            phase_eff = phase_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
         sync_q  <= 1'b0;
      end else if (restart) begin
         phase_q <= '0;
         sync_q  <= 1'b0;
      end else begin
         phase_q <= phase_eff;
         sync_q  <= sync_eff;
      end
   end

endmodule

// File: rtl/oh_rotcap_match.sv
module oh_rotcap_match
   import oh_rotcap_pkg::*;
#(
   parameter int NUM_STS = 48,
   parameter int FRAMES  = 12,
   parameter int STS_W   = 6,
   parameter int PH_W    = 4
) (
   input  logic             in_valid,
   input  logic             in_toh,
   input  logic [3:0]       in_row,
   input  logic [1:0]       in_col,
   input  logic [STS_W-1:0] in_sts,
   input  oh_pos_t          sel,
   input  logic [PH_W-1:0]  phase_eff,
   input  logic             sync_eff,
   input  logic             block,
   output logic             wr_en,
   output logic             wr_last
);

   localparam int GRP       = NUM_STS / FRAMES;
   localparam bit GRP_POW2  = (GRP & (GRP - 1)) == 0;
   localparam int GRP_SHIFT = (GRP > 1) ? $clog2(GRP) : 0;

   logic in_grp;
   logic pos_hit;
   logic sts_ok;

   generate
      if (GRP_POW2) begin : g_shift
         always_comb in_grp = (int'(in_sts) >> GRP_SHIFT) == int'(phase_eff);
      end else begin : g_bounds
         int lo;
         always_comb begin
            lo     = int'(phase_eff) * GRP;
            in_grp = (int'(in_sts) >= lo) && (int'(in_sts) < lo + GRP);
         end
      end
   endgenerate

   always_comb begin
      pos_hit = (in_row == sel.row) && (in_col == sel.col);
      sts_ok  = int'(in_sts) < NUM_STS;
      wr_en   = in_valid && in_toh && !block && sync_eff && pos_hit && sts_ok && in_grp;
      wr_last = (int'(in_sts) == NUM_STS - 1) && (int'(phase_eff) == FRAMES - 1);
   end

endmodule

// File: rtl/oh_rotcap_store.sv
module oh_rotcap_store #(
   parameter int DEPTH  = 48,
   parameter int DATA_W = 8,
   parameter int AW     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en && int'(wr_addr) < DEPTH) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= (int'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;
      end
   end

endmodule

// File: rtl/oh_rotcap.sv
module oh_rotcap
   import oh_rotcap_pkg::*;
#(
   parameter int NUM_STS      = 48,
   parameter int CYCLE_FRAMES = 12,
   parameter int DATA_W       = 8,
   localparam int STS_W       = (NUM_STS > 1) ? $clog2(NUM_STS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_frame_start,
   input  logic              in_oof,
   input  logic              in_toh,
   input  logic [3:0]        in_row,
   input  logic [1:0]        in_col,
   input  logic [STS_W-1:0]  in_sts,
   input  logic [DATA_W-1:0] in_data,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_row,
   input  logic [1:0]        cfg_col,
   input  logic              rd_en,
   input  logic [STS_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              cycle_done
);

   localparam int PH_W = (CYCLE_FRAMES > 1) ? $clog2(CYCLE_FRAMES) : 1;

   generate
      if (CYCLE_FRAMES < 1) begin : g_bad_frames
         $error("oh_rotcap: CYCLE_FRAMES must be at least 1");
      end
      if (NUM_STS < CYCLE_FRAMES || (NUM_STS % CYCLE_FRAMES) != 0) begin : g_bad_sts
         $error("oh_rotcap: NUM_STS must be a positive multiple of CYCLE_FRAMES");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("oh_rotcap: DATA_W must be at least 1");
      end
   endgenerate

   oh_pos_t         sel_q;
   oh_pos_t         cfg_pos;
   logic            cfg_ok;
   logic            restart;
   logic            frame_mark;
   logic [PH_W-1:0] phase_eff;
   logic            sync_eff;
   logic            wr_en;
   logic            wr_last;
   logic            done_set;

   always_comb begin
      cfg_pos    = '{row: cfg_row, col: cfg_col};
      cfg_ok     = cfg_we && oh_pos_legal(cfg_pos);
      restart    = cfg_ok || in_oof;
      frame_mark = in_valid && in_frame_start && !in_oof && !cfg_ok;
      done_set   = wr_en && wr_last;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      sel_q <= '0;
      else if (cfg_ok) sel_q <= cfg_pos;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        cycle_done <= 1'b0;
      else if (done_set) cycle_done <= 1'b1;
      else if (rd_en)    cycle_done <= 1'b0;
   end

   oh_rotcap_seq #(
      .FRAMES (CYCLE_FRAMES),
      .PH_W   (PH_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (restart),
      .frame_mark (frame_mark),
      .phase_eff  (phase_eff),
      .sync_eff   (sync_eff)
   );

   oh_rotcap_match #(
      .NUM_STS (NUM_STS),
      .FRAMES  (CYCLE_FRAMES),
      .STS_W   (STS_W),
      .PH_W    (PH_W)
   ) u_match (
      .in_valid  (in_valid),
      .in_toh    (in_toh),
      .in_row    (in_row),
      .in_col    (in_col),
      .in_sts    (in_sts),
      .sel       (sel_q),
      .phase_eff (phase_eff),
      .sync_eff  (sync_eff),
      .block     (restart),
      .wr_en     (wr_en),
      .wr_last   (wr_last)
   );

   oh_rotcap_store #(
      .DEPTH  (NUM_STS),
      .DATA_W (DATA_W),
      .AW     (STS_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (in_sts),
      .wr_data  (in_data),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

endmodule

// File: rtl/oh_rotcap_chk.sv
module oh_rotcap_chk #(
   parameter int NUM_STS      = 48,
   parameter int CYCLE_FRAMES = 12,
   parameter int STS_W        = 6,
   parameter int PH_W         = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_toh,
   input logic             in_oof,
   input logic             cfg_we,
   input logic [3:0]       cfg_row,
   input logic [1:0]       cfg_col,
   input logic             rd_en,
   input logic             rd_valid,
   input logic             cycle_done,
   input logic             wr_en,
   input logic [STS_W-1:0] in_sts,
   input logic [PH_W-1:0]  phase_eff,
   input logic             sync_eff,
   input logic             restart,
   input logic             frame_mark,
   input logic             done_set
);

   localparam int GRP = NUM_STS / CYCLE_FRAMES;

   a_r1_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   a_r1_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
   a_r3_group_only: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(in_sts) / GRP) == int'(phase_eff));
   a_r4_restart_loses_sync: assert property (@(posedge clk) disable iff (!rst_n)
      $past(restart) && !frame_mark |-> !sync_eff);
   a_r5_done_rises: assert property (@(posedge clk) disable iff (!rst_n)
      done_set |=> cycle_done);
   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !done_set |=> !cycle_done);
   a_r7_no_capture_on_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_row < 4'd9 && cfg_col < 2'd3 |-> !wr_en);
   a_r8_no_capture_oof: assert property (@(posedge clk) disable iff (!rst_n)
      in_oof |-> !wr_en);
   a_r9_only_valid_toh: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> in_valid && in_toh);

endmodule

bind oh_rotcap oh_rotcap_chk #(
   .NUM_STS      (NUM_STS),
   .CYCLE_FRAMES (CYCLE_FRAMES),
   .STS_W        (STS_W),
   .PH_W         (PH_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_toh     (in_toh),
   .in_oof     (in_oof),
   .cfg_we     (cfg_we),
   .cfg_row    (cfg_row),
   .cfg_col    (cfg_col),
   .rd_en      (rd_en),
   .rd_valid   (rd_valid),
   .cycle_done (cycle_done),
   .wr_en      (wr_en),
   .in_sts     (in_sts),
   .phase_eff  (phase_eff),
   .sync_eff   (sync_eff),
   .restart    (restart),
   .frame_mark (frame_mark),
   .done_set   (done_set)
);

// File: tb/tb_oh_rotcap.sv
module tb_oh_rotcap;

   localparam int N     = 36;
   localparam int F     = 12;
   localparam int G     = N / F;
   localparam int SW    = $clog2(N);
   localparam int DW    = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0, in_frame_start = 1'b0, in_oof = 1'b0, in_toh = 1'b0;
   logic [3:0]    in_row = '0;
   logic [1:0]    in_col = '0;
   logic [SW-1:0] in_sts = '0;
   logic [DW-1:0] in_data = '0;
   logic          cfg_we = 1'b0;
   logic [3:0]    cfg_row = '0;
   logic [1:0]    cfg_col = '0;
   logic          rd_en = 1'b0;
   logic [SW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic          cycle_done;

   int checks = 0;
   int failures = 0;
   int tag = 0;
   int sel_r = 0;
   int sel_c = 0;
   logic [DW-1:0] model [N];

   always #10 clk = ~clk;

   oh_rotcap #(.NUM_STS(N), .CYCLE_FRAMES(F), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frame_start(in_frame_start),
      .in_oof(in_oof), .in_toh(in_toh), .in_row(in_row), .in_col(in_col),
      .in_sts(in_sts), .in_data(in_data), .cfg_we(cfg_we), .cfg_row(cfg_row),
      .cfg_col(cfg_col), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .rd_valid(rd_valid), .cycle_done(cycle_done));

   function automatic logic [DW-1:0] byte_of(int t, int r, int c, int s);
      return DW'((t * 53 + r * 17 + c * 7 + s * 5 + 1) & 8'hFF);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One frame: all overhead bytes, then payload and idle bytes that match the selection.
   // k is the frame number the bench expects within the cycle, or -1 for no capture.
   task automatic send_frame(input bit oof, input int k);
      for (int r = 0; r < 9; r++)
         for (int c = 0; c < 3; c++)
            for (int s = 0; s < N; s++) begin
               @(negedge clk);
               in_valid = 1'b1; in_toh = 1'b1; in_oof = oof;
               in_frame_start = (r == 0 && c == 0 && s == 0);
               in_row = 4'(r); in_col = 2'(c); in_sts = SW'(s);
               in_data = byte_of(tag, r, c, s);
               if (k >= 0 && r == sel_r && c == sel_c && s / G == k)
                  model[s] = byte_of(tag, r, c, s);
            end
      // R9: payload bytes and an idle slot carrying a matching position
      for (int p = 0; p < 2; p++) begin
         @(negedge clk);
         in_frame_start = 1'b0; in_toh = 1'b0; in_valid = 1'b1;
         in_row = 4'(sel_r); in_col = 2'(sel_c);
         in_sts = SW'((k < 0 ? 0 : k) * G); in_data = 8'hEE;
      end
      @(negedge clk);
      in_valid = 1'b0; in_toh = 1'b1;
      @(negedge clk);
      in_toh = 1'b0; in_oof = 1'b0;
      tag++;
   endtask

   task automatic cfg(input int r, input int c);
      @(negedge clk);
      cfg_we = 1'b1; cfg_row = 4'(r); cfg_col = 2'(c);
      @(negedge clk);
      cfg_we = 1'b0;
      if (r < 9 && c < 3) begin sel_r = r; sel_c = c; end
   endtask

   task automatic read_all(input string req);
      for (int s = 0; s < N; s++) begin
         @(negedge clk);
         rd_en = 1'b1; rd_addr = SW'(s);
         @(negedge clk);
         rd_en = 1'b0;
         check(rd_valid === 1'b1, {req, " rd_valid"}, int'(rd_valid), 1);
         check(rd_data === model[s], req, int'(rd_data), int'(model[s]));
      end
      @(negedge clk);
      check(rd_valid === 1'b0, "R1 rd_valid drops", int'(rd_valid), 0);
   endtask

   task automatic check_done(input bit exp, input string req);
      check(cycle_done === exp, req, int'(cycle_done), int'(exp));
   endtask

   initial begin
      #(20 * 200000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check_done(1'b0, "R10 cycle_done after reset");
      check(rd_valid === 1'b0, "R10 rd_valid after reset", int'(rd_valid), 0);

      // Default selection (row 0, column 0): a full cycle
      for (int k = 0; k < F; k++) begin
         send_frame(1'b0, k);
         if (k == F - 2) check_done(1'b0, "R5 not done before last frame");
      end
      check_done(1'b1, "R5 done after last frame");
      read_all("R10 R1 R9 default selection");
      check_done(1'b0, "R6 read clears done");

      // New selection; a partial cycle reveals the rotation
      cfg(2, 1);
      for (int k = 0; k < 6; k++) send_frame(1'b0, k);
      read_all("R3 partial cycle");
      cfg(9, 0);   // R2: illegal row, ignored
      cfg(1, 3);   // R2: illegal column, ignored
      for (int k = 6; k < F; k++) send_frame(1'b0, k);
      check_done(1'b1, "R2 illegal writes do not restart");
      read_all("R2 R3 full cycle row2 col1");
      check_done(1'b0, "R6 cleared again");

      // Restart mid-cycle with a new selection
      cfg(5, 0);
      for (int k = 0; k < 5; k++) send_frame(1'b0, k);
      check_done(1'b0, "R7 partial cycle not done");
      cfg(8, 2);
      for (int k = 0; k < F; k++) begin
         send_frame(1'b0, k);
         if (k == F - 2) check_done(1'b0, "R7 restart realigns cycle");
      end
      check_done(1'b1, "R4 R7 done after restarted cycle");
      read_all("R4 R7 row8 col2");

      // Out of frame: nothing captured, cycle restarts at frame 0
      send_frame(1'b1, -1);
      read_all("R8 no capture while out of frame");
      for (int k = 0; k < 3; k++) send_frame(1'b0, k);
      read_all("R4 R8 restart after recovery");
      send_frame(1'b1, -1);
      for (int k = 0; k < F; k++) begin
         send_frame(1'b0, k);
         if (k == F - 2) check_done(1'b0, "R8 cycle lost on out of frame");
      end
      check_done(1'b1, "R4 R8 done after clean cycle");
      read_all("R8 R9 final contents");

      // Frame number wraps: the next cycle continues at frame 0
      send_frame(1'b0, 0);
      read_all("R4 wrap to frame 0");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule